// File: doc/BRIEF.md
# Dual-Processor Mailbox Signalling Controller

Two processors on one chip use this block to tell each other that a message is waiting or that a message has been consumed. Each of up to sixteen channels has one "occupied" flag per processor. A processor posts on a channel by setting its own flag, which raises the peer's receive interrupt. The peer takes the message and then clears that flag, which raises the sender's "channel free" transmit interrupt. The message payload itself lives elsewhere in shared memory.

Each processor has a simple register port with address, write enable, write data and combinational read data. Its register bank holds a control word, a mask word, a write-one set/clear word and a read-only status word. Either port can read both banks and a shared region that describes the configuration. A port can write only to its own bank. The interrupt outputs are registered, so each one is a clean level for the interrupt controller.

Top module: `mbx_ctrl`

## Requirements
- R1: After synchronous reset, all control bits, mask bits and occupied flags are 0, and all four interrupt outputs are low.
- R2: Processor p's bank starts at byte address 0x10*p. Inside a bank, control is at +0x0, mask at +0x4, set/clear at +0x8 and status at +0xC. Both ports can read both banks. The set/clear word reads as 0, and so does every unmapped address.
- R3: Control bit 0 is the receive interrupt enable and control bit 16 is the transmit interrupt enable. All other control bits read 0. In the mask word, bit n masks the receive event of channel n and bit 16+n masks the transmit event of channel n (1 = masked). Both words read back what was written.
- R4: A write of 1 to bit 16+n of a processor's set/clear word sets that processor's own flag for channel n. The status word shows the processor's own flags in bits NUM_CH-1:0.
- R5: A write of 1 to bit n of a processor's set/clear word clears the peer's flag for channel n. Bits written as 0 change nothing.
- R6: A port's writes take effect only in its own bank. Writes from a port to the peer's bank are ignored.
- R7: The receive interrupt of processor p is high when p's receive enable is set and at least one channel has the peer's flag set and p's receive mask bit clear.
- R8: The transmit interrupt of processor p is high when p's transmit enable is set and at least one channel has p's own flag clear and p's transmit mask bit clear.
- R9: The interrupt outputs are registered. They follow a register change one clock after the edge that stores the change.
- R10: Writes from both ports in the same cycle are applied together, bit by bit. When an owner's set and the peer's clear hit the same flag in the same cycle, the set wins.
- R11: Address 0x3F0 reads NUM_CH in bits 7:0. Address 0x3F4 reads the major revision in bits 7:4 and the minor revision in bits 3:0. Writes to either address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_addr | input | 10 | Processor 0 byte address |
| p0_we | input | 1 | Processor 0 write strobe |
| p0_wdata | input | 32 | Processor 0 write data |
| p0_rdata | output | 32 | Processor 0 read data (combinational) |
| p1_addr | input | 10 | Processor 1 byte address |
| p1_we | input | 1 | Processor 1 write strobe |
| p1_wdata | input | 32 | Processor 1 write data |
| p1_rdata | output | 32 | Processor 1 read data (combinational) |
| p0_rx_irq | output | 1 | Processor 0 receive (peer posted) interrupt |
| p0_tx_irq | output | 1 | Processor 0 transmit (channel free) interrupt |
| p1_rx_irq | output | 1 | Processor 1 receive interrupt |
| p1_tx_irq | output | 1 | Processor 1 transmit interrupt |

## Verification
A register write is sampled on one clock edge, and its readback through either port is due in the same cycle, after that edge. The matching interrupt change is due one cycle later. The bench therefore checks each interrupt twice: first at the write cycle, where the old value must still be present, and then one cycle later, where the new value is required. Every expected item carries the cycle number in which it is due. The monitor compares each item on the falling edge of exactly that cycle and reports any item that was never compared.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int ADDR_W      = 10;
    localparam int DATA_W      = 32;
    localparam int MAX_CH      = 16;
    localparam int TX_SHIFT    = 16;
    localparam int BANK_STRIDE = 'h10;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 10'h000;
    localparam logic [ADDR_W-1:0] OFS_MASK = 10'h004;
    localparam logic [ADDR_W-1:0] OFS_SC   = 10'h008;
    localparam logic [ADDR_W-1:0] OFS_STAT = 10'h00C;
    localparam logic [ADDR_W-1:0] ADR_HW   = 10'h3F0;
    localparam logic [ADDR_W-1:0] ADR_VER  = 10'h3F4;

    localparam int RX_EN_BIT = 0;
    localparam int TX_EN_BIT = 16;

    typedef struct packed {
        logic tx_en;
        logic rx_en;
    } ctrl_t;

    function automatic logic [ADDR_W-1:0] bank_base(input int side);
        return ADDR_W'(BANK_STRIDE * side);
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[RX_EN_BIT] = c.rx_en;
        w[TX_EN_BIT] = c.tx_en;
        return w;
    endfunction
endpackage

// File: rtl/mbx_side_regs.sv
module mbx_side_regs
    import mbx_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int SIDE   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic [NUM_CH-1:0] rx_mask,
    output logic [NUM_CH-1:0] tx_mask,
    output logic [NUM_CH-1:0] set_own,
    output logic [NUM_CH-1:0] clr_peer
);
    localparam logic [ADDR_W-1:0] BASE = bank_base(SIDE);

    logic hit_ctrl, hit_mask, hit_sc;

    assign hit_ctrl = we && (addr == BASE + OFS_CTRL);
    assign hit_mask = we && (addr == BASE + OFS_MASK);
    assign hit_sc   = we && (addr == BASE + OFS_SC);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            rx_mask <= '0;
            tx_mask <= '0;
        end else begin
            if (hit_ctrl) begin
                ctrl.rx_en <= wdata[RX_EN_BIT];
                ctrl.tx_en <= wdata[TX_EN_BIT];
            end
            if (hit_mask) begin
                rx_mask <= wdata[NUM_CH-1:0];
                tx_mask <= wdata[TX_SHIFT +: NUM_CH];
            end
        end
    end

    assign set_own  = hit_sc ? wdata[TX_SHIFT +: NUM_CH] : '0;
    assign clr_peer = hit_sc ? wdata[NUM_CH-1:0]         : '0;

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !hit_mask |=> $stable(rx_mask) && $stable(tx_mask)); // R3
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags
    import mbx_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0][NUM_CH-1:0] set_own,
    input  logic [1:0][NUM_CH-1:0] clr_peer,
    output logic [1:0][NUM_CH-1:0] flag
);
    for (genvar s = 0; s < 2; s++) begin : g_side
        localparam int PEER = 1 - s;

        always_ff @(posedge clk) begin
            if (rst) flag[s] <= '0;
            else     flag[s] <= (flag[s] & ~clr_peer[PEER]) | set_own[s];
        end

        AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
            (set_own[s] != '0) |=> ((flag[s] & $past(set_own[s])) == $past(set_own[s]))); // R4
        AST_FALL_BY_PEER: assert property (@(posedge clk) disable iff (rst)
            (($past(flag[s]) & ~flag[s] & ~$past(clr_peer[PEER])) == '0)); // R5
        AST_RISE_BY_OWNER: assert property (@(posedge clk) disable iff (rst)
            ((~$past(flag[s]) & flag[s] & ~$past(set_own[s])) == '0)); // R6
    end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
    import mbx_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [NUM_CH-1:0] rx_mask,
    input  logic [NUM_CH-1:0] tx_mask,
    input  logic [NUM_CH-1:0] own_flag,
    input  logic [NUM_CH-1:0] peer_flag,
    output logic              rx_irq,
    output logic              tx_irq
);
    logic rx_event, tx_event;

    assign rx_event = |(peer_flag & ~rx_mask);
    assign tx_event = |(~own_flag & ~tx_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_irq <= 1'b0;
            tx_irq <= 1'b0;
        end else begin
            rx_irq <= ctrl.rx_en && rx_event;
            tx_irq <= ctrl.tx_en && tx_event;
        end
    end

    AST_RX_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> $past(ctrl.rx_en)); // R7
    AST_TX_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        tx_irq |-> $past(ctrl.tx_en)); // R8
    AST_RX_NEEDS_PEER: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> ($past(peer_flag) != '0)); // R9
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter int         NUM_CH    = 16,
    parameter logic [3:0] VER_MAJOR = 4'd1,
    parameter logic [3:0] VER_MINOR = 4'd2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] p0_addr,
    input  logic              p0_we,
    input  logic [DATA_W-1:0] p0_wdata,
    output logic [DATA_W-1:0] p0_rdata,
    input  logic [ADDR_W-1:0] p1_addr,
    input  logic              p1_we,
    input  logic [DATA_W-1:0] p1_wdata,
    output logic [DATA_W-1:0] p1_rdata,
    output logic              p0_rx_irq,
    output logic              p0_tx_irq,
    output logic              p1_rx_irq,
    output logic              p1_tx_irq
);
    localparam logic [DATA_W-1:0] HW_WORD  = DATA_W'(NUM_CH);
    localparam logic [DATA_W-1:0] VER_WORD = {{(DATA_W-8){1'b0}}, VER_MAJOR, VER_MINOR};

    logic [ADDR_W-1:0]      addr_a  [2];
    logic                   we_a    [2];
    logic [DATA_W-1:0]      wdata_a [2];
    logic [DATA_W-1:0]      rdata_a [2];
    ctrl_t                  ctrl_a  [2];
    logic [NUM_CH-1:0]      rxm_a   [2];
    logic [NUM_CH-1:0]      txm_a   [2];
    logic                   rxi_a   [2];
    logic                   txi_a   [2];
    logic [1:0][NUM_CH-1:0] set_own;
    logic [1:0][NUM_CH-1:0] clr_peer;
    logic [1:0][NUM_CH-1:0] flag;
    logic [DATA_W-1:0]      ctrl_w  [2];
    logic [DATA_W-1:0]      mask_w  [2];
    logic [DATA_W-1:0]      stat_w  [2];

    assign addr_a[0]  = p0_addr;
    assign addr_a[1]  = p1_addr;
    assign we_a[0]    = p0_we;
    assign we_a[1]    = p1_we;
    assign wdata_a[0] = p0_wdata;
    assign wdata_a[1] = p1_wdata;
    assign p0_rdata   = rdata_a[0];
    assign p1_rdata   = rdata_a[1];
    assign p0_rx_irq  = rxi_a[0];
    assign p0_tx_irq  = txi_a[0];
    assign p1_rx_irq  = rxi_a[1];
    assign p1_tx_irq  = txi_a[1];

    for (genvar s = 0; s < 2; s++) begin : g_side
        mbx_side_regs #(.NUM_CH(NUM_CH), .SIDE(s)) u_regs (
            .clk      (clk),
            .rst      (rst),
            .addr     (addr_a[s]),
            .we       (we_a[s]),
            .wdata    (wdata_a[s]),
            .ctrl     (ctrl_a[s]),
            .rx_mask  (rxm_a[s]),
            .tx_mask  (txm_a[s]),
            .set_own  (set_own[s]),
            .clr_peer (clr_peer[s])
        );

        mbx_irq #(.NUM_CH(NUM_CH)) u_irq (
            .clk       (clk),
            .rst       (rst),
            .ctrl      (ctrl_a[s]),
            .rx_mask   (rxm_a[s]),
            .tx_mask   (txm_a[s]),
            .own_flag  (flag[s]),
            .peer_flag (flag[1-s]),
            .rx_irq    (rxi_a[s]),
            .tx_irq    (txi_a[s])
        );

        always_comb begin
            ctrl_w[s] = ctrl_word(ctrl_a[s]);
            mask_w[s] = '0;
            mask_w[s][NUM_CH-1:0]          = rxm_a[s];
            mask_w[s][TX_SHIFT +: NUM_CH]  = txm_a[s];
            stat_w[s] = '0;
            stat_w[s][NUM_CH-1:0]          = flag[s];
        end
    end

    mbx_flags #(.NUM_CH(NUM_CH)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_own  (set_own),
        .clr_peer (clr_peer),
        .flag     (flag)
    );

    for (genvar p = 0; p < 2; p++) begin : g_rd
        always_comb begin
            rdata_a[p] = '0;
            for (int b = 0; b < 2; b++) begin
                if (addr_a[p] == bank_base(b) + OFS_CTRL) rdata_a[p] = ctrl_w[b];
                if (addr_a[p] == bank_base(b) + OFS_MASK) rdata_a[p] = mask_w[b];
                if (addr_a[p] == bank_base(b) + OFS_STAT) rdata_a[p] = stat_w[b];
            end
            if (addr_a[p] == ADR_HW)  rdata_a[p] = HW_WORD;
            if (addr_a[p] == ADR_VER) rdata_a[p] = VER_WORD;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !p0_rx_irq && !p0_tx_irq && !p1_rx_irq && !p1_tx_irq); // R1
endmodule

// File: tb/mbx_ctrl_tb.sv
module mbx_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  p0_addr = 10'h3FC, p1_addr = 10'h3FC;
    logic        p0_we = 1'b0, p1_we = 1'b0;
    logic [31:0] p0_wdata = '0, p1_wdata = '0;
    logic [31:0] p0_rdata, p1_rdata;
    logic        p0_rx_irq, p0_tx_irq, p1_rx_irq, p1_tx_irq;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        int          sel;
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sbq[$];

    mbx_ctrl u_dut (
        .clk(clk), .rst(rst),
        .p0_addr(p0_addr), .p0_we(p0_we), .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
        .p1_addr(p1_addr), .p1_we(p1_we), .p1_wdata(p1_wdata), .p1_rdata(p1_rdata),
        .p0_rx_irq(p0_rx_irq), .p0_tx_irq(p0_tx_irq),
        .p1_rx_irq(p1_rx_irq), .p1_tx_irq(p1_tx_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares queued items on the falling edge of their due cycle
    always @(negedge clk) begin
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].due <= cyc) begin
                logic [31:0] act;
                case (sbq[i].sel)
                    0:       act = {28'b0, p1_rx_irq, p1_tx_irq, p0_rx_irq, p0_tx_irq};
                    1:       act = p0_rdata;
                    default: act = p1_rdata;
                endcase
                n_chk++;
                if (sbq[i].due < cyc) begin
                    n_fail++;
                    $display("FAIL %s missed its cycle: actual %h expected %h", sbq[i].req, act, sbq[i].exp);
                end else if (act !== sbq[i].exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", sbq[i].req, act, sbq[i].exp);
                end
                sbq.delete(i);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push(int due, int sel, logic [31:0] exp, string req);
        item_t it;
        it.due = due; it.sel = sel; it.exp = exp; it.req = req;
        sbq.push_back(it);
    endtask

    task automatic wr(int side, logic [9:0] a, logic [31:0] d);
        tick();
        if (side == 0) begin p0_addr = a; p0_wdata = d; p0_we = 1'b1; end
        else           begin p1_addr = a; p1_wdata = d; p1_we = 1'b1; end
        tick();
        p0_we = 1'b0; p1_we = 1'b0;
    endtask

    task automatic wr_both(logic [9:0] a0, logic [31:0] d0, logic [9:0] a1, logic [31:0] d1);
        tick();
        p0_addr = a0; p0_wdata = d0; p0_we = 1'b1;
        p1_addr = a1; p1_wdata = d1; p1_we = 1'b1;
        tick();
        p0_we = 1'b0; p1_we = 1'b0;
    endtask

    task automatic rd(int side, logic [9:0] a, logic [31:0] exp, string req);
        tick();
        if (side == 0) p0_addr = a; else p1_addr = a;
        push(cyc, side + 1, exp, req);
    endtask

    // irq vector order {p1_rx, p1_tx, p0_rx, p0_tx}
    task automatic irq_at(int delay, logic [3:0] exp, string req);
        push(cyc + delay, 0, {28'b0, exp}, req);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) tick();
        rst = 1'b0;
        // R1 reset state
        irq_at(0, 4'b0000, "R1 irqs");
        rd(0, 10'h000, 32'h0, "R1 ctrl0");
        rd(1, 10'h014, 32'h0, "R1 mask1");
        rd(0, 10'h00C, 32'h0, "R1 stat0");
        // R11 configuration words, R2 unmapped
        rd(1, 10'h3F0, 32'h10, "R11 hwcfg");
        rd(0, 10'h3F4, 32'h12, "R11 version");
        wr(0, 10'h3F0, 32'hFF);
        rd(0, 10'h3F0, 32'h10, "R11 hwcfg write ignored");
        rd(1, 10'h100, 32'h0, "R2 unmapped");
        // R3 control: only bits 0 and 16 stick; R8 tx fires with no own flags
        wr(0, 10'h000, 32'hFFFF_FFFF);
        irq_at(0, 4'b0000, "R9 tx irq not yet");
        irq_at(1, 4'b0001, "R8 tx free irq");
        rd(1, 10'h000, 32'h0001_0001, "R3 ctrl0 via port1");
        // R3 mask readback, masking the tx event
        wr(0, 10'h004, 32'hFFFF_FFFF);
        rd(0, 10'h004, 32'hFFFF_FFFF, "R3 mask0");
        irq_at(0, 4'b0000, "R8 tx masked");
        // R4 p1 posts channel 3
        wr(1, 10'h018, 32'h0008_0000);
        rd(0, 10'h01C, 32'h0000_0008, "R4 stat1 via port0");
        rd(0, 10'h00C, 32'h0, "R4 stat0 unchanged");
        irq_at(0, 4'b0000, "R7 rx masked");
        wr(0, 10'h004, 32'hFFFF_FFF7);
        irq_at(0, 4'b0000, "R9 rx not yet");
        irq_at(1, 4'b0010, "R7 rx unmasked");
        // R6 p0 writing into bank1 is ignored
        wr(0, 10'h018, 32'h0000_0008);
        rd(1, 10'h01C, 32'h0000_0008, "R6 peer bank set/clear ignored");
        wr(0, 10'h014, 32'hFFFF_FFFF);
        rd(1, 10'h014, 32'h0, "R6 peer bank mask ignored");
        // R5 zeros have no effect
        wr(0, 10'h008, 32'h0);
        rd(1, 10'h01C, 32'h0000_0008, "R5 zero write");
        rd(0, 10'h008, 32'h0, "R2 set/clear reads zero");
        // R5 p0 clears p1 channel 3
        wr(0, 10'h008, 32'h0000_0008);
        irq_at(0, 4'b0010, "R9 rx still high");
        irq_at(1, 4'b0000, "R7 rx drops");
        rd(1, 10'h01C, 32'h0, "R5 cleared by peer");
        // R10 simultaneous writes
        wr(1, 10'h018, 32'h0004_0000);
        wr(0, 10'h008, 32'h0002_0000);
        rd(0, 10'h00C, 32'h0000_0002, "R4 stat0 ch1");
        wr_both(10'h008, 32'h0020_0004, 10'h018, 32'h0080_0002);
        rd(0, 10'h00C, 32'h0000_0020, "R10 stat0 after dual write");
        rd(1, 10'h01C, 32'h0000_0080, "R10 stat1 after dual write");
        wr_both(10'h008, 32'h0200_0000, 10'h018, 32'h0000_0200);
        rd(1, 10'h00C, 32'h0000_0220, "R10 set wins over clear");
        // R8 channel-free interrupt for p1
        wr(1, 10'h010, 32'h0001_0000);
        irq_at(1, 4'b0100, "R8 p1 tx free");
        wr(1, 10'h014, 32'hFF7F_FFFF);
        irq_at(1, 4'b0000, "R8 p1 only ch7 unmasked, occupied");
        wr(0, 10'h008, 32'h0000_0080);
        irq_at(1, 4'b0100, "R8 p1 ch7 freed");
        // R1 reset again clears state
        tick();
        rst = 1'b1;
        repeat (2) tick();
        rst = 1'b0;
        rd(0, 10'h00C, 32'h0, "R1 stat0 after reset");
        irq_at(0, 4'b0000, "R1 irqs after reset");
        repeat (4) tick();
        if (sbq.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard: actual %0d items left expected 0", sbq.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule